// File: doc/BRIEF.md
# Configuration Image Selection Sequencer

This block decides which configuration image a reconfigurable device loads and where in flash that image starts. It models the control side only. A load attempt finishes with a one-cycle `load_done` or `load_err` pulse from the loader. Requests come from four sources: the power-on reset, an external configuration pulse, a reconfiguration request from user logic that carries a start address, and a watchdog timeout raised while the application runs.

The sequencer has two states. In the loading state it waits for the loader's outcome. In the running state it accepts new requests. An application image that fails to load is retried at the same address, and each failure raises a counter. When the counter passes its limit, the sequencer falls back to the factory image. Every move to the factory image latches a one-hot cause word, which later tells the factory software why it is running.

Top module: `cfg_image_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `loading`=1, `app_mode`=0, `load_addr`=0, `err_cnt`=0 and `cause`=0.
- R2: A `load_done` pulse in the loading state, with no `load_err` in the same cycle, moves the block to the running state (`loading`=0) on the next edge. A `user_req` or `wdt_timeout` that arrives while `loading`=1 has no effect.
- R3: A `user_req` in the running state with `user_addr`=0 starts a factory load: `app_mode`=0, `load_addr`=0, `loading`=1, and `cause`=5'b00100 (bit 2 means the trigger came from user logic).
- R4: A `user_req` in the running state with a nonzero `user_addr` starts an application load: `app_mode`=1, `load_addr`=`user_addr`, `loading`=1, and `cause` is cleared to 0.
- R5: A `load_err` during an application load keeps the same address and increments `err_cnt`. On the error that would take the count past MAX_RETRY (default 3, so the fourth error), the block switches to a factory load with `err_cnt`=0 and `cause`=5'b00001 (bit 0 means a load error). When `load_err` and `load_done` arrive together, the error takes precedence.
- R6: A successful application load (`load_done` without `load_err`) clears `err_cnt` to 0.
- R7: A `wdt_timeout` in the running state while `app_mode`=1 starts a factory load with `cause`=5'b10000 (bit 4). In factory running mode, `wdt_timeout` is ignored.
- R8: An `ext_cfg` pulse in either state starts a factory load: `loading`=1, `app_mode`=0, `load_addr`=0, `err_cnt`=0 and `cause`=5'b01000 (bit 3).
- R9: When several requests arrive in the same cycle, `ext_cfg` wins over `wdt_timeout`, and `wdt_timeout` wins over `user_req`. `cause` never has more than one bit set.
- R10: A `load_err` during a factory load retries the factory image: `loading` stays 1, `app_mode` stays 0 and `err_cnt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_cfg | input | 1 | External configuration pulse |
| user_req | input | 1 | Reconfiguration request from user logic |
| user_addr | input | AW | Start address for `user_req`; 0 selects the factory image |
| load_done | input | 1 | Pulse: the current load completed |
| load_err | input | 1 | Pulse: the current load failed |
| wdt_timeout | input | 1 | User watchdog expired |
| loading | output | 1 | 1 while a load is in progress |
| app_mode | output | 1 | 1 = application image, 0 = factory image |
| load_addr | output | AW | Flash start address of the selected image |
| err_cnt | output | CW | Application load failures since the last clear |
| cause | output | 5 | Latched one-hot reason for the last reconfiguration |

## Verification
Two pairs of events can land in the same clock cycle: a watchdog timeout together with a user request, and an external pulse together with a watchdog timeout. The bench provokes each pair by raising both inputs in the same cycle while the application is running. It judges the result by the cause word and the mode flag: they must show that only the higher-priority source acted. A further collision is a load error arriving with a load-done pulse; the bench expects the error count to rise and the block to stay in the loading state.

// File: rtl/cfg_image_seq.sv
module cfg_image_seq #(
  parameter int AW = 32,
  parameter int MAX_RETRY = 3,
  localparam int CW = $clog2(MAX_RETRY + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_cfg,
  input  logic          user_req,
  input  logic [AW-1:0] user_addr,
  input  logic          load_done,
  input  logic          load_err,
  input  logic          wdt_timeout,
  output logic          loading,
  output logic          app_mode,
  output logic [AW-1:0] load_addr,
  output logic [CW-1:0] err_cnt,
  output logic [4:0]    cause
);

  localparam logic [4:0] C_WDT  = 5'b10000;
  localparam logic [4:0] C_EXT  = 5'b01000;
  localparam logic [4:0] C_USER = 5'b00100;
  localparam logic [4:0] C_LERR = 5'b00001;

  wire run      = !loading;
  wire wdt_hit  = run && app_mode && wdt_timeout;
  wire req_hit  = run && user_req;
  wire give_up  = err_cnt == CW'(MAX_RETRY);

  task automatic to_factory(input logic [4:0] why);
    loading   <= 1'b1;
    app_mode  <= 1'b0;
    load_addr <= '0;
    err_cnt   <= '0;
    cause     <= why;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading   <= 1'b1;
      app_mode  <= 1'b0;
      load_addr <= '0;
      err_cnt   <= '0;
      cause     <= '0;
    end else if (ext_cfg) begin
      to_factory(C_EXT);
    end else if (wdt_hit) begin
      to_factory(C_WDT);
    end else if (req_hit) begin
      if (user_addr == '0) begin
        to_factory(C_USER);
      end else begin
        loading   <= 1'b1;
        app_mode  <= 1'b1;
        load_addr <= user_addr;
        cause     <= '0;
      end
    end else if (loading && load_err) begin
      if (app_mode) begin
        if (give_up) to_factory(C_LERR);
        else err_cnt <= err_cnt + 1'b1;
      end
    end else if (loading && load_done) begin
      loading <= 1'b0;
      if (app_mode) err_cnt <= '0;
    end
  end

  AST_EXT_FACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cfg |=> (loading && !app_mode && load_addr == '0 && err_cnt == '0 && cause == C_EXT)); // R8

  AST_DONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && load_done && !load_err && !ext_cfg) |=> !loading); // R2

  AST_WDT_FACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && app_mode && wdt_timeout && !ext_cfg) |=> (loading && !app_mode && cause == C_WDT)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= CW'(MAX_RETRY)); // R5

  AST_RETRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && app_mode && load_err && !give_up && !ext_cfg) |=> (loading && app_mode && $stable(load_addr))); // R5

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause)); // R9

  AST_FACTORY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !app_mode && load_err && !ext_cfg) |=> (loading && !app_mode && err_cnt == '0)); // R10

endmodule

// File: tb/cfg_image_seq_bench.sv
module cfg_image_seq_bench;
  localparam int AW = 32;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_cfg = 1'b0, user_req = 1'b0, load_done = 1'b0, load_err = 1'b0, wdt_timeout = 1'b0;
  logic [AW-1:0] user_addr = '0;
  logic loading, app_mode;
  logic [AW-1:0] load_addr;
  logic [CW-1:0] err_cnt;
  logic [4:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_image_seq u_cfg_image_seq (
    .clk(clk), .rst_n(rst_n), .ext_cfg(ext_cfg), .user_req(user_req),
    .user_addr(user_addr), .load_done(load_done), .load_err(load_err),
    .wdt_timeout(wdt_timeout), .loading(loading), .app_mode(app_mode),
    .load_addr(load_addr), .err_cnt(err_cnt), .cause(cause)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic state_is(input string req, input logic ld, input logic am,
                          input logic [AW-1:0] a, input logic [CW-1:0] c, input logic [4:0] cs);
    chk(req, "loading", 64'(loading), 64'(ld));
    chk(req, "app_mode", 64'(app_mode), 64'(am));
    chk(req, "load_addr", 64'(load_addr), 64'(a));
    chk(req, "err_cnt", 64'(err_cnt), 64'(c));
    chk(req, "cause", 64'(cause), 64'(cs));
  endtask

  task automatic idle();
    ext_cfg = 0; user_req = 0; load_done = 0; load_err = 0; wdt_timeout = 0; user_addr = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic done_pulse();  load_done = 1; tick(); endtask
  task automatic err_pulse();   load_err = 1;  tick(); endtask
  task automatic request(input logic [AW-1:0] a); user_req = 1; user_addr = a; tick(); endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk);
    state_is("R1", 1, 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    state_is("R1", 1, 0, 0, 0, 0);
  endtask

  task automatic t_app_load();
    request(32'h0000_1000);
    chk("R2", "req ignored while loading", 64'(app_mode), 64'd0);
    wdt_timeout = 1; tick();
    chk("R2", "wdt ignored while loading", 64'(cause), 64'd0);
    done_pulse();
    chk("R2", "running", 64'(loading), 64'd0);
    request(32'h0100_0000);
    state_is("R4", 1, 1, 32'h0100_0000, 0, 0);
    done_pulse();
    state_is("R2", 0, 1, 32'h0100_0000, 0, 0);
  endtask

  task automatic t_retry();
    request(32'h0200_0000);
    err_pulse();
    state_is("R5", 1, 1, 32'h0200_0000, 1, 0);
    load_err = 1; load_done = 1; tick();
    state_is("R5", 1, 1, 32'h0200_0000, 2, 0);
    err_pulse();
    state_is("R5", 1, 1, 32'h0200_0000, 3, 0);
    err_pulse();
    state_is("R5", 1, 0, 0, 0, 5'b00001);
    done_pulse();
  endtask

  task automatic t_success_clears();
    request(32'h0300_0000);
    err_pulse();
    err_pulse();
    chk("R6", "count before success", 64'(err_cnt), 64'd2);
    done_pulse();
    state_is("R6", 0, 1, 32'h0300_0000, 0, 0);
  endtask

  task automatic t_wdt();
    wdt_timeout = 1; tick();
    state_is("R7", 1, 0, 0, 0, 5'b10000);
    done_pulse();
    wdt_timeout = 1; tick();
    state_is("R7", 0, 0, 0, 0, 5'b10000);
  endtask

  task automatic t_user_factory();
    request(32'h0400_0000);
    done_pulse();
    request('0);
    state_is("R3", 1, 0, 0, 0, 5'b00100);
    done_pulse();
  endtask

  task automatic t_ext();
    request(32'h0500_0000);
    err_pulse();
    err_pulse();
    ext_cfg = 1; tick();
    state_is("R8", 1, 0, 0, 0, 5'b01000);
    done_pulse();
    ext_cfg = 1; tick();
    state_is("R8", 1, 0, 0, 0, 5'b01000);
    done_pulse();
  endtask

  task automatic t_prio();
    request(32'h0600_0000);
    done_pulse();
    wdt_timeout = 1; user_req = 1; user_addr = 32'h0700_0000; tick();
    state_is("R9", 1, 0, 0, 0, 5'b10000);
    done_pulse();
    request(32'h0600_0000);
    done_pulse();
    ext_cfg = 1; wdt_timeout = 1; user_req = 1; user_addr = '0; tick();
    state_is("R9", 1, 0, 0, 0, 5'b01000);
  endtask

  task automatic t_factory_err();
    err_pulse();
    state_is("R10", 1, 0, 0, 0, 5'b01000);
    err_pulse();
    err_pulse();
    err_pulse();
    err_pulse();
    state_is("R10", 1, 0, 0, 0, 5'b01000);
    done_pulse();
    chk("R10", "factory runs after retry", 64'(loading), 64'd0);
  endtask

  initial begin
    idle();
    t_reset();
    t_app_load();
    t_retry();
    request(32'h0300_0000);
    done_pulse();
    t_success_clears();
    t_wdt();
    t_user_factory();
    t_ext();
    t_prio();
    t_factory_err();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule